// File: doc/BRIEF.md
# Edge-Event Capture Sampler and Multiplexer

This block carries sparse events from several free-running sources onto one slow synchronous bitstream. Each source supplies a short active-low set pulse, typically made from the rising edge of a frequency-encoding oscillator. The pulse asynchronously sets a capture flag for that channel. The flag holds the event until the channel's turn comes in the outgoing bitstream. The flag's value is then sent and the flag is cleared on the sampling clock. A flag that was set asynchronously and cleared synchronously puts each event into the stream once. A wide one-shot would sometimes send an event twice, and a narrow one could miss it.

A slot strobe marks each opportunity to send one bit. Slots go to the channels in a fixed rotation, channel 0, 1, 2, then back to 0. Each strobe yields one output beat that carries the bit and the index of the channel it belongs to. Before the flag is read, its value passes through a synchronizer into the clock domain. When a flag is cleared while a new set pulse is still active, the new event wins and is kept for that channel's next turn.

The output is valid-only and has no ready signal. The line timing that drives the strobe allows no stall, so the sink must take every beat in the cycle it appears. A channel whose flag is not set still gets its slot, and that slot carries a 0.

Top module: `evt_slot_sampler`

## Requirements
- R1: Synchronous reset (`rst` high on a clock edge) clears every capture flag and the synchronizers, sets `out_valid` to 0, and returns the slot counter to 0. The first strobe after reset therefore produces `out_slot` = 0.
- R2: When `evt_set_n[i]` goes low, even for less than a clock period, and is released at least three rising clock edges before a strobe edge addressed to channel i, that beat has `out_bit` = 1.
- R3: After a captured event has been sent as a 1, the same channel's next slot carries 0, provided no new set pulse arrived in between.
- R4: Each strobe edge advances the addressed channel in the order 0, 1, 2, 0. A beat's `out_slot` equals the channel that its bit was read from.
- R5: A strobe reads and clears only the addressed channel. Events held in the other channels are still reported as 1 at their own slots.
- R6: When `evt_set_n[i]` is low at the edge where channel i's flag is cleared, the set wins. The channel's next slot again carries 1.
- R7: Without a strobe, `out_valid` stays 0 and the slot counter does not move. Captured flags are held for as long as the strobe is absent.
- R8: `out_valid` is high for exactly the one cycle that follows each strobe edge. `out_bit` and `out_slot` are meaningful only in that cycle.
- R9: A reset that arrives in the middle of a rotation discards events that have not been sent, and the rotation restarts at channel 0.
- R10: Several set pulses on one channel before its slot merge into a single 1, followed by 0 on the next slot of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_set_n | input | 3 | Asynchronous active-low set pulse, one per channel |
| slot_strobe | input | 1 | One-cycle marker that a bitstream slot is available |
| out_valid | output | 1 | Output beat present; no back-pressure |
| out_bit | output | 1 | Sampled flag value for the addressed channel |
| out_slot | output | 2 | Channel index of the beat (0 to 2) |

## Verification
The tests apply set pulses narrower than a clock period on single channels, on two channels together, as repeated pulses on one channel, and as a pulse held low across its own clearing edge. The single-channel and repeated-pulse patterns show whether an event is sent once or is repeated or merged wrongly. The two-channel pattern shows that a clear acts only on the addressed channel. The pulse held across the clearing edge separates set priority from a lost event. Long gaps with no strobe, and a reset applied partway through a rotation, check that the flags are held and that the rotation restarts at channel 0.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned DEF_CHANNELS    = 3;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/evt_capture_cell.sv
module evt_capture_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic set_n,
  input  logic clr,
  output logic seen
);
  logic                   flag;
  logic [SYNC_STAGES-1:0] chain;

  // asynchronous set with priority, synchronous clear
  always_ff @(posedge clk or negedge set_n) begin
    if (!set_n)        flag <= 1'b1;
    else if (rst || clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-2:0], flag};
  end

  assign seen = chain[SYNC_STAGES-1];

  // R6: an active set at a clock edge keeps the flag up
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    !set_n |-> flag);

  // R3: the flag drops only after a clearing read
  a_r3_clear_only_by_read: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(clr));

  // R1: synchronizer output is low right after reset
  a_r1_sync_reset: assert property (@(posedge clk)
    $past(rst) |-> !seen);
endmodule

// File: rtl/evt_slot_seq.sv
module evt_slot_seq #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CH - 1);

  always_ff @(posedge clk) begin
    if (rst)           slot <= '0;
    else if (adv)      slot <= (slot == LAST) ? '0 : slot + 1'b1;
  end

  // R4: counter never leaves the channel range
  a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
    slot <= LAST);

  // R4: wrap from the last channel to channel 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && slot == LAST) |=> slot == '0);

  // R7: no strobe, no movement
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(slot));
endmodule

// File: rtl/evt_slot_out.sv
module evt_slot_out #(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              bit_in,
  input  logic [SLOT_W-1:0] slot_in,
  output logic              out_valid,
  output logic              out_bit,
  output logic [SLOT_W-1:0] out_slot
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_slot  <= '0;
    end else begin
      out_valid <= strobe;
      if (strobe) begin
        out_bit  <= bit_in;
        out_slot <= slot_in;
      end
    end
  end

  // R8: a beat always follows a strobe
  a_r8_beat_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(strobe));

  // R4: beat index is the slot addressed at the strobe
  a_r4_index_matches: assert property (@(posedge clk) disable iff (rst)
    strobe |=> out_slot == $past(slot_in));
endmodule

// File: rtl/evt_slot_sampler.sv
module evt_slot_sampler #(
  parameter int unsigned NUM_CH      = evt_pkg::DEF_CHANNELS,
  parameter int unsigned SYNC_STAGES = evt_pkg::DEF_SYNC_STAGES
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [NUM_CH-1:0]                     evt_set_n,
  input  logic                                  slot_strobe,
  output logic                                  out_valid,
  output logic                                  out_bit,
  output logic [evt_pkg::idx_width(NUM_CH)-1:0] out_slot
);
  localparam int unsigned SLOT_W = evt_pkg::idx_width(NUM_CH);

  logic [NUM_CH-1:0] seen;
  logic [NUM_CH-1:0] clr;
  logic [SLOT_W-1:0] slot;
  logic              pick;

  evt_slot_seq #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_seq (
    .clk (clk),
    .rst (rst),
    .adv (slot_strobe),
    .slot(slot)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // clear only a channel that was read as 1 on this strobe
    assign clr[g] = slot_strobe && (slot == SLOT_W'(g)) && seen[g];

    evt_capture_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .set_n(evt_set_n[g]),
      .clr  (clr[g]),
      .seen (seen[g])
    );
  end

  always_comb begin
    pick = 1'b0;
    for (int i = 0; i < NUM_CH; i++)
      if (slot == SLOT_W'(i)) pick = seen[i];
  end

  evt_slot_out #(.SLOT_W(SLOT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .strobe   (slot_strobe),
    .bit_in   (pick),
    .slot_in  (slot),
    .out_valid(out_valid),
    .out_bit  (out_bit),
    .out_slot (out_slot)
  );

  // R5: at most one channel is cleared per strobe
  a_r5_single_clear: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr));
endmodule

// File: tb/test_evt_slot_sampler.sv
module test_evt_slot_sampler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] evt_set_n = 3'b111;
  logic       slot_strobe = 1'b0;
  logic       out_valid, out_bit;
  logic [1:0] out_slot;

  int tests = 0;
  int fails = 0;
  int exp_slot = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_slot_sampler i_evt_slot_sampler (
    .clk(clk), .rst(rst), .evt_set_n(evt_set_n),
    .slot_strobe(slot_strobe), .out_valid(out_valid),
    .out_bit(out_bit), .out_slot(out_slot)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    #1 evt_set_n[ch] = 1'b0;
    #2 evt_set_n[ch] = 1'b1;
    idle(3);
  endtask

  task automatic do_slot(input bit eb, input string req);
    @(negedge clk); slot_strobe = 1'b1;
    @(negedge clk); slot_strobe = 1'b0;
    chk(out_valid == 1'b1, "R8 valid", int'(out_valid), 1);
    chk(int'(out_slot) == exp_slot, "R4 slot", int'(out_slot), exp_slot);
    chk(out_bit == eb, req, int'(out_bit), int'(eb));
    exp_slot = (exp_slot + 1) % 3;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 single", int'(out_valid), 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    idle(3);
    rst = 1'b0;
    exp_slot = 0;
    chk(out_valid == 1'b0, "R1 valid low", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    do_slot(1'b0, "R1 empty 0");
    do_slot(1'b0, "R1 empty 1");
    do_slot(1'b0, "R1 empty 2");
  endtask

  task automatic t_single();   // R2, R3
    pulse(0);
    do_slot(1'b1, "R2 ch0 capture");
    do_slot(1'b0, "R3 ch1 none");
    do_slot(1'b0, "R3 ch2 none");
    do_slot(1'b0, "R3 ch0 once");
  endtask

  task automatic t_two();      // R5
    pulse(0); pulse(2);
    do_slot(1'b0, "R5 ch1 empty");
    do_slot(1'b1, "R5 ch2 kept");
    do_slot(1'b1, "R5 ch0 kept");
    do_slot(1'b0, "R5 ch1 after");
    do_slot(1'b0, "R5 ch2 once");
    do_slot(1'b0, "R5 ch0 once");
  endtask

  task automatic t_race();     // R6, exp_slot is 1 here
    pulse(1);
    @(negedge clk); slot_strobe = 1'b1; evt_set_n[1] = 1'b0;
    @(negedge clk); slot_strobe = 1'b0; evt_set_n[1] = 1'b1;
    chk(out_bit == 1'b1, "R6 first", int'(out_bit), 1);
    chk(int'(out_slot) == 1, "R6 slot", int'(out_slot), 1);
    exp_slot = 2;
    idle(3);
    do_slot(1'b0, "R6 ch2");
    do_slot(1'b0, "R6 ch0");
    do_slot(1'b1, "R6 set wins");
    do_slot(1'b0, "R6 ch2 b");
    do_slot(1'b0, "R6 ch0 b");
    do_slot(1'b0, "R6 then clear");
  endtask

  task automatic t_idle_hold(); // R7, exp_slot is 2
    pulse(2);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 no beat", int'(out_valid), 0);
    end
    do_slot(1'b1, "R7 held ch2");
    chk(int'(out_slot) == 2, "R7 slot unmoved", int'(out_slot), 2);
  endtask

  task automatic t_merge();    // R10, exp_slot is 0
    do_slot(1'b0, "R10 ch0");
    pulse(1); pulse(1);
    do_slot(1'b1, "R10 merged");
    do_slot(1'b0, "R10 ch2");
    do_slot(1'b0, "R10 ch0 b");
    do_slot(1'b0, "R10 once");
  endtask

  task automatic t_mid_reset(); // R9, exp_slot is 2
    pulse(0);
    pulse(2);
    do_reset();
    do_slot(1'b0, "R9 ch0 dropped");
    do_slot(1'b0, "R9 ch1");
    do_slot(1'b0, "R9 ch2 dropped");
    chk(int'(out_slot) == 2, "R9 order", int'(out_slot), 2);
  endtask

  initial begin
    t_reset();
    t_single();
    t_two();
    t_race();
    t_idle_hold();
    t_merge();
    t_mid_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule